// File: doc/BRIEF.md
# Limit-Based Counter-Timer with Interrupt

This block is a single up-counting timer that sits behind a small 32-bit word-addressed register port. Each cycle in which the `tick_en` input is high counts as one 500 ns period. On that cycle the count advances by one unit of bit `FRAC`, and the bits below it always read as zero. Software programs a limit. When the count reaches the limit, the block sets a sticky reached flag and raises a level interrupt. On the tick after that, the count wraps to zero and keeps running. A limit of zero turns the block into a free-running counter that climbs to its largest representable value before it wraps.

There are two ways to write the limit. One write restarts the count from zero and drops the interrupt. The other changes only the limit and leaves the running count alone. A read of the limit word acknowledges the event: it drops the interrupt and clears the reached flag. The counter word returns the count with the reached flag in its top bit. The tick comes from outside as a one-cycle enable, so the block has no divider of its own.

Top module: `lim_ctr_timer`

## Requirements
- R1: After reset the limit, the count, the reached flag and `irq` are all zero, and the counter advances on the first tick.
- R2: Each cycle with `tick_en` high (and no restarting limit write) advances the count by one unit of bit `FRAC`. Without a tick, the count holds. Bits `FRAC-1:0` of the limit and counter words always read as zero.
- R3: A read at byte offset 0x4 returns the reached flag in bit 31 and the count in bits `CNT_W-1:FRAC`. All other bits are zero.
- R4: A write at offset 0x0 stores `wdata` masked to bits `CNT_W-1:FRAC` (0x7FFFFE00 at defaults) as the limit. It sets the count to zero even if `tick_en` is high in the same cycle, and it deasserts `irq`.
- R5: A write at offset 0x8 stores the limit with the same mask and leaves the count alone. A tick in that same cycle still advances the count, and the match test for that tick uses the previous limit.
- R6: A read at offset 0x0 returns the limit in bits `CNT_W-1:FRAC` with bit 31 zero. After the read, `irq` and the reached flag are cleared, unless a limit match happens in that same cycle, in which case the match wins.
- R7: When a tick moves the count onto the target, the reached flag and `irq` are set in the next cycle. The target is the limit, or the maximum count when the limit is zero. Both stay set until they are cleared as described in R4 and R6.
- R8: A tick while the count equals the target, or equals the maximum count, wraps the count to zero and does not signal a new match.
- R9: With a zero limit the count runs to the maximum value (all ones in bits `CNT_W-1:FRAC`, 0x7FFFFE00 at defaults), signals a match there, and then wraps.
- R10: Reads at offsets 0x8, 0xC, 0x10 and any other undecoded word return zero. Writes at offsets 0x4, 0xC and any other undecoded word change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle timebase enable, one per 500 ns period |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; bits 4:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that each register access lasts exactly one cycle and that `tick_en` is a single-cycle pulse sampled on the rising edge. They also assume that a read sees the state from before that edge. The stimulus drives every input on the falling edge and holds it for one full cycle. Random ticks and random register accesses are mixed over all eight word offsets. A narrow counter width keeps the free-run wrap reachable. Directed cases place a tick in the same cycle as a restarting write, a limit-keeping write and an acknowledging read, and they cover the cases where the count passes a limit that was lowered under it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    W_LIMIT      = 3'd0,
    W_COUNT      = 3'd1,
    W_LIMIT_KEEP = 3'd2,
    W_STATUS     = 3'd3,
    W_AUX        = 3'd4
  } word_e;

  typedef struct packed {
    logic rd_limit;
    logic wr_limit;
    logic wr_keep;
    logic rd_count;
  } bus_op_t;

  // place a unit count at its bit position inside a data word
  function automatic logic [DATA_W-1:0] place_units(input logic [DATA_W-1:0] units,
                                                    input int unsigned frac);
    return units << frac;
  endfunction

  // extract the unit field from a data word
  function automatic logic [DATA_W-1:0] take_units(input logic [DATA_W-1:0] word,
                                                   input int unsigned frac,
                                                   input int unsigned uw);
    logic [DATA_W-1:0] m;
    m = (DATA_W'(1) << uw) - DATA_W'(1);
    return (word >> frac) & m;
  endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
(
  input  logic       sel,
  input  logic       wr,
  input  logic [4:0] addr,
  output word_e      word,
  output bus_op_t    op
);
  always_comb begin
    word = word_e'(addr[4:2]);
    op = '0;
    if (sel) begin
      op.rd_limit = !wr && (word == W_LIMIT);
      op.wr_limit =  wr && (word == W_LIMIT);
      op.wr_keep  =  wr && (word == W_LIMIT_KEEP);
      op.rd_count = !wr && (word == W_COUNT);
    end
  end
endmodule

// File: rtl/tmr_limit_reg.sv
module tmr_limit_reg
  import tmr_pkg::*;
#(
  parameter int UW   = 22,
  parameter int FRAC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [UW-1:0]     lim_u
);
  always_ff @(posedge clk) begin
    if (!rst_n)    lim_u <= '0;
    else if (load) lim_u <= UW'(take_units(wdata, FRAC, UW));
  end

  a_r4_limit_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> lim_u == UW'($past(wdata) >> FRAC));
  a_r10_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lim_u));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int UW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [UW-1:0] lim_u,
  output logic [UW-1:0] cnt_u,
  output logic          hit
);
  localparam logic [UW-1:0] MAX_U = {UW{1'b1}};

  logic [UW-1:0] target;
  logic [UW-1:0] nxt;
  logic          at_end;

  always_comb begin
    target = (lim_u == '0) ? MAX_U : lim_u;
    at_end = (cnt_u == target) || (cnt_u == MAX_U);
    nxt    = cnt_u + UW'(1);
    hit    = tick && !restart && !at_end && (nxt == target);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_u <= '0;
    else if (restart) cnt_u <= '0;
    else if (tick)    cnt_u <= at_end ? '0 : nxt;
  end

  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_u == '0);
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_u));
  a_r8_wrap_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && cnt_u == MAX_U) |=> cnt_u == '0);
  a_r7_hit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt_u == $past(target));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_irq,
  input  logic clr_reached,
  output logic reached,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (hit)              reached <= 1'b1;
      else if (clr_reached) reached <= 1'b0;
      if (hit)              irq <= 1'b1;
      else if (clr_irq)     irq <= 1'b0;
    end
  end

  a_r7_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (irq && reached));
  a_r6_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_irq));
  a_r6_reached_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reached) |-> $past(clr_reached));
endmodule

// File: rtl/lim_ctr_timer.sv
module lim_ctr_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 31,
  parameter int FRAC  = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int UW = CNT_W - FRAC;

  word_e         word;
  bus_op_t       op;
  logic [UW-1:0] lim_u;
  logic [UW-1:0] cnt_u;
  logic          hit;
  logic          reached;
  logic          clr_irq;

  assign clr_irq = op.rd_limit || op.wr_limit;

  tmr_decode u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .word(word), .op(op)
  );

  tmr_limit_reg #(.UW(UW), .FRAC(FRAC)) u_lim (
    .clk(clk), .rst_n(rst_n), .load(op.wr_limit || op.wr_keep),
    .wdata(bus_wdata), .lim_u(lim_u)
  );

  tmr_counter #(.UW(UW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .restart(op.wr_limit),
    .lim_u(lim_u), .cnt_u(cnt_u), .hit(hit)
  );

  tmr_flags u_flg (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_irq(clr_irq),
    .clr_reached(op.rd_limit), .reached(reached), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (op.rd_limit)
      bus_rdata = place_units(DATA_W'(lim_u), FRAC);
    else if (op.rd_count)
      bus_rdata = place_units(DATA_W'(cnt_u), FRAC) | {reached, 31'd0};
  end

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[FRAC-1:0] == '0);
  a_r10_undecoded_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[4:2] != 3'd0 && bus_addr[4:2] != 3'd1)
      |-> bus_rdata == '0);
  a_r6_limit_bit31_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[4:2] == 3'd0) |-> !bus_rdata[31]);
endmodule

// File: tb/tb_lim_ctr_timer.sv
module tb_lim_ctr_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int FR = 9;
  localparam int MAXU = (1 << (CW - FR)) - 1;

  logic clk = 0, rst_n = 0, tick_en = 0, bus_sel = 0, bus_wr = 0, irq;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;

  int errors = 0, checks = 0;
  int m_lim = 0, m_cnt = 0;
  bit m_reached = 0, m_irq = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lim_ctr_timer #(.CNT_W(CW), .FRAC(FR)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_read(int w);
    if (w == 0) return 32'(m_lim) << FR;
    if (w == 1) return (32'(m_cnt) << FR) | {m_reached, 31'd0};
    return 32'd0;
  endfunction

  function automatic string read_tag(int w);
    if (w == 0) return "R6";
    if (w == 1) return "R3";
    return "R10";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; read data and irq checked before the edge, model stepped after it
  task automatic step(bit sel, bit wr, int w, logic [31:0] wd, bit tk);
    int tgt, nxt;
    bit hit;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = 5'(w << 2); bus_wdata = wd; tick_en = tk;
    #1;
    if (sel && !wr) check(read_tag(w), bus_rdata, exp_read(w));
    check("R7 irq", 32'(irq), 32'(m_irq));
    @(posedge clk);
    hit = 0;
    tgt = (m_lim == 0) ? MAXU : m_lim;
    if (sel && wr && w == 0) m_cnt = 0;
    else if (tk) begin
      if (m_cnt == tgt || m_cnt == MAXU) m_cnt = 0;
      else begin
        nxt = m_cnt + 1;
        hit = (nxt == tgt);
        m_cnt = nxt;
      end
    end
    if (sel && wr && (w == 0 || w == 2)) m_lim = int'((wd >> FR) & MAXU);
    if (hit) begin m_reached = 1; m_irq = 1; end
    else begin
      if (sel && !wr && w == 0) m_reached = 0;
      if (sel && w == 0) m_irq = 0;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    ticks(3);
    step(1, 0, 1, 0, 0); // R2: three units counted
    // R4: masked limit, restart, tick in same cycle ignored
    step(1, 1, 0, 32'hFFFF_FFFF, 1);
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    // R7: match at limit 5
    step(1, 1, 0, 32'(5 << FR) | 32'h1FF, 0);
    ticks(5);
    step(1, 0, 1, 0, 0); // R3 reached bit + count 5
    ticks(1);             // R8 wrap
    step(1, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0); // R6 ack
    step(1, 0, 1, 0, 0);
    // R6: match during acknowledging read wins
    ticks(4);
    step(1, 0, 0, 0, 1);
    step(1, 0, 1, 0, 0);
    // R5: keep-write lowers limit under count; count passes it and wraps at max
    step(1, 1, 0, 32'(20 << FR), 0);
    ticks(10);
    step(1, 1, 2, 32'(4 << FR), 1);
    step(1, 0, 1, 0, 0);
    ticks(MAXU - 11);
    step(1, 0, 1, 0, 0);
    ticks(1);
    step(1, 0, 1, 0, 0);
    // R9: free run to maximum count
    step(1, 1, 0, 0, 0);
    ticks(MAXU);
    step(1, 0, 1, 0, 0);
    ticks(1);
    step(1, 0, 1, 0, 0);
    // R10: undecoded reads zero, writes ignored
    step(1, 0, 2, 0, 0);
    step(1, 0, 3, 0, 0);
    step(1, 0, 4, 0, 0);
    step(1, 1, 1, 32'hFFFF_FFFF, 0);
    step(1, 1, 3, 32'hFFFF_FFFF, 0);
    step(1, 1, 5, 32'hFFFF_FFFF, 0);
    step(1, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      automatic int r = $urandom_range(0, 99);
      automatic int w = $urandom_range(0, 7);
      automatic bit sel = (r < 25);
      automatic bit wr = sel && ($urandom_range(0, 3) == 0);
      automatic logic [31:0] wd = $urandom;
      if ($urandom_range(0, 2) == 0) wd = wd & 32'h0000_1E00;
      step(sel, wr, w, wd, $urandom_range(0, 1) == 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule